// File: doc/BRIEF.md
# Split-Aware Bus Arbiter

This block decides which of several bus masters owns a shared AHB-style bus. Each master raises its own request line. The arbiter returns a registered one-hot grant vector and the index of the owner. The owner index is meant to steer the address and data multiplexers that sit outside this block. The arbiter watches the slave response and the ready signal, so ownership passes only at the end of a completed transfer.

A slave can answer with SPLIT to free the bus while it prepares a slow reply. When the two-cycle SPLIT response completes, the arbiter records the current owner in a per-master hold mask. That master takes no part in arbitration until the slave sets the master's bit in the split re-enable vector. A RETRY response does not set any mask bit. It only lets the arbiter choose again, so a master with higher priority can go ahead of the one that was retried. A response whose first cycle is not followed by its matching second cycle raises a one-cycle protocol error flag.

Among the masters that are not held, the lowest index wins. Master 0 is the park master. It receives the grant when no eligible master is requesting.

Top module: `ahb_split_arbiter`

## Requirements
- R1: While reset is held and after it is released, the grant vector is 1 (master 0), the owner index is 0 and the protocol error flag is low, with all hold-mask bits clear.
- R2: On a cycle with ready high, the grant registered at that clock edge goes to the lowest-indexed master that is requesting and is not held. The grant vector never has more than one bit set.
- R3: On a ready-high cycle where no eligible master is requesting, master 0 is granted if it is not held. If master 0 is held, the grant vector becomes all zero.
- R4: On a cycle with ready low, the grant vector and owner index do not change.
- R5: Response codes are 00 OKAY, 01 ERROR, 10 RETRY and 11 SPLIT. A cycle showing 11 with ready high, directly after a cycle showing 11 with ready low, sets the hold bit of the current owner. A held master is never granted.
- R6: A set bit in the split re-enable vector clears that master's hold bit at the same clock edge, so the master can win arbitration on that same cycle. If a hold bit is set and cleared on the same cycle, it ends up set.
- R7: A completed RETRY response (10 with ready low, then 10 with ready high) sets no hold bit. The arbiter re-arbitrates on its second cycle, so a lower-indexed requester takes the bus from the retried master.
- R8: If a cycle shows RETRY or SPLIT with ready low, and the next cycle does not show the same code with ready high, the protocol error flag is high for exactly the cycle after that next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | NUM_MST | Request line per master |
| slv_resp | input | 2 | Slave response code (00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT) |
| slv_ready | input | 1 | Transfer-complete indication from the slave |
| split_reen | input | NUM_MST | Per-master split re-enable from the slave |
| bus_gnt | output | NUM_MST | Registered one-hot grant |
| gnt_idx | output | IDX_W | Registered index of the current owner |
| proto_err | output | 1 | One-cycle response protocol error pulse |

## Verification
The hardest case to reach from the ports is a held master that competes again. First that master must become the owner. Then a full two-cycle SPLIT must arrive while it still owns the bus. Its re-enable bit may then arrive before, during or after further splits of other masters, sometimes in the very cycle of a new split. Directed sequences first make each master the sole requester, then split it and re-enable it. They also split master 0 with no other requester, which empties the grant. A long pseudo-random run then mixes request patterns, response codes, ready values and sparse re-enable bits, and compares every cycle with a model of masks and ownership kept in the bench.

// File: rtl/ahb_arb_pkg.sv
package ahb_arb_pkg;
  typedef enum logic [1:0] {
    RSP_OKAY  = 2'b00,
    RSP_ERROR = 2'b01,
    RSP_RETRY = 2'b10,
    RSP_SPLIT = 2'b11
  } rsp_e;
endpackage

// File: rtl/ahb_arb_resp_track.sv
module ahb_arb_resp_track
  import ahb_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] resp,
  input  logic       ready,
  output logic       split_done,
  output logic       err_q
);
  logic       pend_q;
  logic [1:0] pend_code_q;
  logic       opening;

  // first half of a two-cycle RETRY/SPLIT: high code bit with ready low
  assign opening    = resp[1] & ~ready;
  assign split_done = pend_q && (pend_code_q == RSP_SPLIT) &&
                      (resp == RSP_SPLIT) && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_code_q <= RSP_OKAY;
      err_q       <= 1'b0;
    end else begin
      pend_q      <= opening;
      pend_code_q <= resp;
      err_q       <= pend_q && !((resp == pend_code_q) && ready);
    end
  end
endmodule

// File: rtl/ahb_arb_hold_mask.sv
module ahb_arb_hold_mask #(
  parameter int NUM_MST = 16,
  localparam int IDX_W = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic [NUM_MST-1:0] clr,
  output logic [NUM_MST-1:0] mask_nxt
);
  logic [NUM_MST-1:0] mask_q;

  always_comb begin
    mask_nxt = mask_q & ~clr;
    if (set_en) mask_nxt[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nxt;
  end
endmodule

// File: rtl/ahb_arb_prio.sv
module ahb_arb_prio #(
  parameter int NUM_MST = 16,
  localparam int IDX_W = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic [NUM_MST-1:0] cand,
  output logic               found,
  output logic [IDX_W-1:0]   win
);
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NUM_MST - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        win   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ahb_split_arbiter.sv
module ahb_split_arbiter
  import ahb_arb_pkg::*;
#(
  parameter int NUM_MST = 16,
  localparam int IDX_W = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_MST-1:0] bus_req,
  input  logic [1:0]         slv_resp,
  input  logic               slv_ready,
  input  logic [NUM_MST-1:0] split_reen,
  output logic [NUM_MST-1:0] bus_gnt,
  output logic [IDX_W-1:0]   gnt_idx,
  output logic               proto_err
);
  logic               split_done;
  logic               own_vld_q;
  logic [NUM_MST-1:0] mask_nxt;
  logic [NUM_MST-1:0] eligible;
  logic               found;
  logic [IDX_W-1:0]   win;
  logic               nxt_vld;
  logic [IDX_W-1:0]   nxt_idx;

  ahb_arb_resp_track u_resp (
    .clk        (clk),
    .rst        (rst),
    .resp       (slv_resp),
    .ready      (slv_ready),
    .split_done (split_done),
    .err_q      (proto_err)
  );

  ahb_arb_hold_mask #(.NUM_MST(NUM_MST)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .set_en   (split_done & own_vld_q),
    .set_idx  (gnt_idx),
    .clr      (split_reen),
    .mask_nxt (mask_nxt)
  );

  assign eligible = bus_req & ~mask_nxt;

  ahb_arb_prio #(.NUM_MST(NUM_MST)) u_prio (
    .cand  (eligible),
    .found (found),
    .win   (win)
  );

  // park on master 0 when nobody eligible asks, unless master 0 is held
  always_comb begin
    if (found) begin
      nxt_vld = 1'b1;
      nxt_idx = win;
    end else begin
      nxt_vld = ~mask_nxt[0];
      nxt_idx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_vld_q <= 1'b1;
      gnt_idx   <= '0;
      bus_gnt   <= NUM_MST'(1);
    end else if (slv_ready) begin
      own_vld_q <= nxt_vld;
      gnt_idx   <= nxt_idx;
      bus_gnt   <= nxt_vld ? (NUM_MST'(1) << nxt_idx) : '0;
    end
  end
endmodule

// File: rtl/ahb_split_arbiter_chk.sv
module ahb_split_arbiter_chk
  import ahb_arb_pkg::*;
#(
  parameter int NUM_MST = 16,
  localparam int IDX_W = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_MST-1:0] bus_req,
  input logic [1:0]         slv_resp,
  input logic               slv_ready,
  input logic [NUM_MST-1:0] split_reen,
  input logic [NUM_MST-1:0] bus_gnt,
  input logic [IDX_W-1:0]   gnt_idx,
  input logic               proto_err
);
  logic               split_open_q;
  logic [NUM_MST-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      split_open_q <= 1'b0;
      held_q       <= '0;
    end else begin
      split_open_q <= (slv_resp == RSP_SPLIT) && !slv_ready;
      for (int i = 0; i < NUM_MST; i++) begin
        if (split_open_q && (slv_resp == RSP_SPLIT) && slv_ready && bus_gnt[i])
          held_q[i] <= 1'b1;
        else if (split_reen[i])
          held_q[i] <= 1'b0;
      end
    end
  end

  // R2
  onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_gnt));

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !slv_ready |=> ($stable(bus_gnt) && $stable(gnt_idx)));

  // R5
  held_not_granted_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_gnt & held_q) == '0);

  // R8
  split_broken_chk: assert property (@(posedge clk) disable iff (rst)
    ((slv_resp == RSP_SPLIT) && !slv_ready) ##1 !((slv_resp == RSP_SPLIT) && slv_ready)
    |=> proto_err);

  // R8
  retry_broken_chk: assert property (@(posedge clk) disable iff (rst)
    ((slv_resp == RSP_RETRY) && !slv_ready) ##1 !((slv_resp == RSP_RETRY) && slv_ready)
    |=> proto_err);
endmodule

bind ahb_split_arbiter ahb_split_arbiter_chk #(.NUM_MST(NUM_MST)) u_chk (.*);

// File: tb/ahb_split_arbiter_tb.sv
module ahb_split_arbiter_tb;
  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  bus_req = '0;
  logic [1:0]    slv_resp = 2'b00;
  logic          slv_ready = 1'b1;
  logic [N-1:0]  split_reen = '0;
  logic [N-1:0]  bus_gnt;
  logic [IW-1:0] gnt_idx;
  logic          proto_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  logic [N-1:0]  m_mask = '0;
  logic          m_vld  = 1'b1;
  int            m_own  = 0;
  logic [1:0]    m_pend_code = 2'b00;
  logic          m_pend = 1'b0;
  logic          m_err  = 1'b0;
  logic [31:0]   lfsr   = 32'h1234_5678;

  always #2 clk = ~clk;

  ahb_split_arbiter #(.NUM_MST(N)) u_dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .slv_resp(slv_resp),
    .slv_ready(slv_ready), .split_reen(split_reen), .bus_gnt(bus_gnt),
    .gnt_idx(gnt_idx), .proto_err(proto_err)
  );

  task automatic check_out(input string tag);
    logic [N-1:0] eg;
    eg = m_vld ? (N'(1) << m_own) : '0;
    checks++;
    if (bus_gnt !== eg || proto_err !== m_err || (m_vld && gnt_idx !== IW'(m_own))) begin
      fails++;
      $display("FAIL %s: gnt=%b idx=%0d err=%b expected gnt=%b idx=%0d err=%b",
               tag, bus_gnt, gnt_idx, proto_err, eg, m_own, m_err);
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic [1:0] rs, input logic rd,
                      input logic [N-1:0] re, input string tag);
    logic [N-1:0] nm;
    logic [N-1:0] el;
    int w;
    @(negedge clk);
    bus_req = r; slv_resp = rs; slv_ready = rd; split_reen = re;
    @(posedge clk);
    #1;
    m_err = m_pend && !((rs == m_pend_code) && rd);
    nm = m_mask & ~re;
    if (m_pend && m_pend_code == 2'b11 && rs == 2'b11 && rd && m_vld) nm[m_own] = 1'b1;
    if (rd) begin
      el = r & ~nm;
      w = -1;
      for (int i = N - 1; i >= 0; i--) if (el[i]) w = i;
      if (w >= 0) begin m_vld = 1'b1; m_own = w; end
      else begin m_vld = ~nm[0]; m_own = 0; end
    end
    m_mask = nm;
    m_pend = rs[1] && !rd;
    m_pend_code = rs;
    check_out(tag);
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_out("R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_out("R1 after reset");

    // R2 R3: every request pattern on a free bus
    for (int p = 0; p < (1 << N); p++) step(N'(p), 2'b00, 1'b1, '0, "R2 R3 sweep");

    // R4: ready low freezes grant whatever the requests
    step(4'b1000, 2'b00, 1'b1, '0, "R2 setup");
    for (int p = 0; p < (1 << N); p++) step(N'(p), 2'b00, 1'b0, '0, "R4 hold");

    // R5 R6: split each master, check skip, re-enable
    for (int i = 0; i < N; i++) begin
      step(N'(1) << i, 2'b00, 1'b1, '0, "R2 own");
      step('1, 2'b11, 1'b0, '0, "R4 split first");
      step('1, 2'b11, 1'b1, '0, "R5 split second");
      step('1, 2'b00, 1'b1, '0, "R5 masked skip");
      step('0, 2'b00, 1'b1, '0, "R3 R5 park");
      step('1, 2'b00, 1'b1, N'(1) << i, "R6 reenable");
    end

    // R6: set and clear in same cycle, set wins
    step(4'b0100, 2'b00, 1'b1, '0, "R2 own2");
    step(4'b0100, 2'b11, 1'b0, '0, "R4 split first");
    step(4'b0110, 2'b11, 1'b1, 4'b0100, "R6 set wins");
    step(4'b0100, 2'b00, 1'b1, '0, "R6 still held");
    step(4'b0100, 2'b00, 1'b1, 4'b0100, "R6 released");

    // R7: retry, no mask, higher priority wins
    step(4'b1000, 2'b00, 1'b1, '0, "R2 own3");
    step(4'b1010, 2'b10, 1'b0, '0, "R4 retry first");
    step(4'b1010, 2'b10, 1'b1, '0, "R7 retry second");
    step(4'b1000, 2'b00, 1'b1, '0, "R7 not masked");

    // R8: broken response pairs
    step(4'b0001, 2'b11, 1'b0, '0, "R8 first");
    step(4'b0001, 2'b00, 1'b1, '0, "R8 broken");
    step(4'b0001, 2'b00, 1'b1, '0, "R8 flag");
    step(4'b0001, 2'b10, 1'b0, '0, "R8 first");
    step(4'b0001, 2'b11, 1'b1, '0, "R8 wrong code");
    step(4'b0001, 2'b00, 1'b1, '0, "R8 flag");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] re;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      re = (lfsr[15:13] == 3'b000) ? lfsr[19:16] : '0;
      step(lfsr[3:0], lfsr[5:4], (lfsr[8:6] != 3'b000), re, "R2,R3,R5,R6,R7,R8 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule